// File: doc/BRIEF.md
# Physical Memory Access Checker and Router

This block takes one physical memory request at a time (instruction fetch, data load, or store/AMO) and decides where it goes. Each request carries an address, a size code, and three ordering flags: acquire, release, and reserved/conditional. The block does four things in turn:

- It validates the size.
- It enforces alignment for ordered reserved or conditional accesses.
- It turns the flags into an ordering kind.
- It applies the protection and RAM-side permission verdicts that arrive alongside the request.

The request then goes to the memory-mapped I/O port or the RAM port, or it ends as a fault. A single response reports either data plus the ordering kind, or an error with a 4-bit code.

The protection verdict and the RAM-side permission verdict are sampled in the cycle the request is accepted. Reads and writes each have their own I/O region window. Every window test covers the full byte span of the access. The fixed evaluation order is: size, alignment, unsupported flags, protection, I/O window, RAM window, RAM permission, then fault.

Top module: `mem_access_dispatch`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `mmio_req` and `ram_req` are 0.
- R2: Size code s selects 2^s bytes for s = 0..4. Size codes 5 to 7 respond with error code 15 (not implemented), and this check comes before all others.
- R3: A read is misaligned when the address modulo the width is nonzero. A misaligned read responds with error code 4 only if acquire or reserved is set. A misaligned plain read, or one with only release set, is not rejected for alignment.
- R4: A write responds with error code 6 when it is misaligned and release or conditional is set.
- R5: Read flags {acquire, release, reserved} give a kind on `rsp_kind`/`dn_kind`: 000→0, 100→1, 110→2, 001→3, 101→4, 111→5. Flags 010 and 011 respond with error code 15 when no alignment error applies.
- R6: Write flags {acquire, release, conditional} give a kind: 000→0, 010→1, 001→2, 011→3, 110→4, 111→5. Flags 100 and 101 respond with error code 15 when no alignment error applies.
- R7: With `prot_en` and `prot_fault` both high, a request that passes R2 to R6 responds with an error whose code is `prot_code`. When `prot_en` is low, `prot_fault` has no effect.
- R8: A read whose whole span [addr, addr+width) lies inside the readable I/O window is sent to the I/O port. A write is sent there when its span lies inside the writable I/O window. The I/O check takes priority over RAM.
- R9: A request whose span lies inside the RAM window goes to the RAM port if `ram_perm_ok` is high. Otherwise it responds with an error whose code is `ram_perm_code`.
- R10: A request that hits no window faults. A read with `req_type` 0 (fetch) gets code 1, a read with type 1 (load) gets code 5, and any other read or any write gets code 7.
- R11: A successful response has `rsp_err` 0, code 0 and the decoded kind. Read data comes from the serving port, with bytes at and above the width forced to zero. A write returns zero data, and an error response has kind 0.
- R12: Only one request is in flight. `req_ready` is high only when idle. A response stays valid and stable until `rsp_ready`, and a port request stays high until its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and accepting |
| req_we | input | 1 | 1 = write, 0 = read |
| req_type | input | 2 | Read class: 0 fetch, 1 load, else store/AMO |
| req_addr | input | AW | Physical byte address |
| req_size | input | 3 | Size code, width = 2^code bytes |
| req_aq | input | 1 | Acquire flag |
| req_rl | input | 1 | Release flag |
| req_rsv | input | 1 | Reserved (read) / conditional (write) flag |
| req_wdata | input | DW | Write data |
| prot_en | input | 1 | Protection checking enabled |
| prot_fault | input | 1 | Protection verdict: access denied |
| prot_code | input | 4 | Exception code for a protection denial |
| ram_perm_ok | input | 1 | RAM-side permission verdict |
| ram_perm_code | input | 4 | Exception code for a RAM-side denial |
| dn_we | output | 1 | Downstream write flag |
| dn_addr | output | AW | Downstream address |
| dn_size | output | 3 | Downstream size code |
| dn_wdata | output | DW | Downstream write data |
| dn_kind | output | 3 | Downstream ordering kind |
| mmio_req | output | 1 | I/O port request |
| mmio_ack | input | 1 | I/O port done |
| mmio_rdata | input | DW | I/O read data |
| ram_req | output | 1 | RAM port request |
| ram_ack | input | 1 | RAM port done |
| ram_rdata | input | DW | RAM read data |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Response taken |
| rsp_err | output | 1 | Response is an exception |
| rsp_code | output | 4 | Exception code |
| rsp_kind | output | 3 | Ordering kind of a successful access |
| rsp_rdata | output | DW | Zero-extended read data |

## Verification
The hardest cases to reach are the ones where two checks compete. Examples are a misaligned reserved read that also carries an unsupported flag pattern, a write whose span fits the readable I/O window but not the writable one, and a denied protection verdict on a request that would otherwise fault for having no window. The stimulus sweeps every flag pattern, size, direction and read class across addresses chosen at window edges and at each misalignment. It repeats the sweep under all four combinations of protection enable and verdict, and changes the RAM permission from request to request. It also holds `rsp_ready` low for a varying number of cycles, so that response stability is checked under back-pressure.

// File: rtl/mad_pkg.sv
package mad_pkg;
  localparam logic [3:0] EXC_NONE      = 4'd0;
  localparam logic [3:0] EXC_FETCH_ACC = 4'd1;
  localparam logic [3:0] EXC_LD_MISAL  = 4'd4;
  localparam logic [3:0] EXC_LD_ACC    = 4'd5;
  localparam logic [3:0] EXC_ST_MISAL  = 4'd6;
  localparam logic [3:0] EXC_ST_ACC    = 4'd7;
  localparam logic [3:0] EXC_NOT_IMPL  = 4'd15;

  localparam logic [1:0] TYPE_FETCH = 2'd0;
  localparam logic [1:0] TYPE_LOAD  = 2'd1;

  typedef enum logic [1:0] {ST_IDLE, ST_MMIO, ST_RAM, ST_RESP} disp_state_e;
  typedef enum logic [1:0] {RT_RESP, RT_MMIO, RT_RAM} route_e;
endpackage

// File: rtl/mad_flag_decode.sv
module mad_flag_decode (
  input  logic       is_write,
  input  logic       aq,
  input  logic       rl,
  input  logic       rsv,
  output logic [2:0] kind,
  output logic       unsupported,
  output logic       align_needed
);
  always_comb begin
    kind        = 3'd0;
    unsupported = 1'b0;
    if (is_write) begin
      case ({aq, rl, rsv})
        3'b000:  kind = 3'd0;
        3'b010:  kind = 3'd1;
        3'b001:  kind = 3'd2;
        3'b011:  kind = 3'd3;
        3'b110:  kind = 3'd4;
        3'b111:  kind = 3'd5;
        default: unsupported = 1'b1;
      endcase
    end else begin
      case ({aq, rl, rsv})
        3'b000:  kind = 3'd0;
        3'b100:  kind = 3'd1;
        3'b110:  kind = 3'd2;
        3'b001:  kind = 3'd3;
        3'b101:  kind = 3'd4;
        3'b111:  kind = 3'd5;
        default: unsupported = 1'b1;
      endcase
    end
    align_needed = is_write ? (rl | rsv) : (aq | rsv);
  end
endmodule

// File: rtl/mad_span_check.sv
module mad_span_check #(
  parameter int             AW   = 32,
  parameter int             NBW  = 5,
  parameter logic [AW-1:0]  BASE = '0,
  parameter logic [AW:0]    SPAN = '0
) (
  input  logic [AW-1:0]  addr,
  input  logic [NBW-1:0] nbytes,
  output logic           hit
);
  localparam logic [AW:0] LO_LIM = {1'b0, BASE};
  localparam logic [AW:0] HI_LIM = LO_LIM + SPAN;

  logic [AW:0] first_b;
  logic [AW:0] end_b;

  always_comb begin
    first_b = {1'b0, addr};
    end_b   = first_b + (AW+1)'(nbytes);
    hit     = (first_b >= LO_LIM) && (end_b <= HI_LIM);
  end
endmodule

// File: rtl/mem_access_dispatch.sv
module mem_access_dispatch
  import mad_pkg::*;
#(
  parameter int            AW         = 32,
  parameter int            DW         = 128,
  parameter logic [AW-1:0] RD_IO_BASE = 32'h1000_0000,
  parameter logic [AW:0]   RD_IO_SPAN = 33'h0000_1000,
  parameter logic [AW-1:0] WR_IO_BASE = 32'h1000_0000,
  parameter logic [AW:0]   WR_IO_SPAN = 33'h0000_0800,
  parameter logic [AW-1:0] RAM_BASE   = 32'h8000_0000,
  parameter logic [AW:0]   RAM_SPAN   = 33'h0001_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [1:0]    req_type,
  input  logic [AW-1:0] req_addr,
  input  logic [2:0]    req_size,
  input  logic          req_aq,
  input  logic          req_rl,
  input  logic          req_rsv,
  input  logic [DW-1:0] req_wdata,
  input  logic          prot_en,
  input  logic          prot_fault,
  input  logic [3:0]    prot_code,
  input  logic          ram_perm_ok,
  input  logic [3:0]    ram_perm_code,
  output logic          dn_we,
  output logic [AW-1:0] dn_addr,
  output logic [2:0]    dn_size,
  output logic [DW-1:0] dn_wdata,
  output logic [2:0]    dn_kind,
  output logic          mmio_req,
  input  logic          mmio_ack,
  input  logic [DW-1:0] mmio_rdata,
  output logic          ram_req,
  input  logic          ram_ack,
  input  logic [DW-1:0] ram_rdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic          rsp_err,
  output logic [3:0]    rsp_code,
  output logic [2:0]    rsp_kind,
  output logic [DW-1:0] rsp_rdata
);
  localparam int NB    = DW / 8;
  localparam int MAXSZ = $clog2(NB);
  localparam int NBW   = MAXSZ + 1;

  // request-side decode
  logic           size_ok;
  logic [NBW-1:0] nbytes;
  logic           misal;
  logic [2:0]     dec_kind;
  logic           dec_unsup;
  logic           dec_align;
  logic           rd_io_hit, wr_io_hit, ram_hit;

  always_comb begin
    size_ok = (req_size <= 3'(MAXSZ));
    nbytes  = size_ok ? (NBW'(1) << req_size) : NBW'(1);
    misal   = |(req_addr[NBW-1:0] & (nbytes - NBW'(1)));
  end

  mad_flag_decode u_flags (
    .is_write    (req_we),
    .aq          (req_aq),
    .rl          (req_rl),
    .rsv         (req_rsv),
    .kind        (dec_kind),
    .unsupported (dec_unsup),
    .align_needed(dec_align)
  );

  mad_span_check #(.AW(AW), .NBW(NBW), .BASE(RD_IO_BASE), .SPAN(RD_IO_SPAN)) u_rd_io (
    .addr(req_addr), .nbytes(nbytes), .hit(rd_io_hit));
  mad_span_check #(.AW(AW), .NBW(NBW), .BASE(WR_IO_BASE), .SPAN(WR_IO_SPAN)) u_wr_io (
    .addr(req_addr), .nbytes(nbytes), .hit(wr_io_hit));
  mad_span_check #(.AW(AW), .NBW(NBW), .BASE(RAM_BASE), .SPAN(RAM_SPAN)) u_ram (
    .addr(req_addr), .nbytes(nbytes), .hit(ram_hit));

  // priority chain: size, alignment, flags, protection, I/O, RAM, fault
  logic       acc_err;
  logic [3:0] acc_code;
  route_e     acc_route;
  logic [3:0] miss_code;

  always_comb begin
    if (req_we)                      miss_code = EXC_ST_ACC;
    else if (req_type == TYPE_FETCH) miss_code = EXC_FETCH_ACC;
    else if (req_type == TYPE_LOAD)  miss_code = EXC_LD_ACC;
    else                             miss_code = EXC_ST_ACC;

    acc_err   = 1'b1;
    acc_code  = EXC_NONE;
    acc_route = RT_RESP;
    if (!size_ok) begin
      acc_code = EXC_NOT_IMPL;
    end else if (dec_align && misal) begin
      acc_code = req_we ? EXC_ST_MISAL : EXC_LD_MISAL;
    end else if (dec_unsup) begin
      acc_code = EXC_NOT_IMPL;
    end else if (prot_en && prot_fault) begin
      acc_code = prot_code;
    end else if (req_we ? wr_io_hit : rd_io_hit) begin
      acc_err   = 1'b0;
      acc_route = RT_MMIO;
    end else if (ram_hit) begin
      if (ram_perm_ok) begin
        acc_err   = 1'b0;
        acc_route = RT_RAM;
      end else begin
        acc_code = ram_perm_code;
      end
    end else begin
      acc_code = miss_code;
    end
  end

  // state and held request
  disp_state_e    state_q, state_d;
  logic           we_q;
  logic [AW-1:0]  addr_q;
  logic [2:0]     size_q;
  logic [NBW-1:0] nb_q;
  logic [DW-1:0]  wdata_q;
  logic [2:0]     kind_q;
  logic           err_q;
  logic [3:0]     code_q;
  logic [DW-1:0]  rdata_q;

  logic           accept;
  logic           port_done;
  logic [DW-1:0]  port_data;
  logic [DW-1:0]  keep_mask;

  assign accept    = req_valid && (state_q == ST_IDLE);
  assign port_done = ((state_q == ST_MMIO) && mmio_ack) || ((state_q == ST_RAM) && ram_ack);
  assign port_data = (state_q == ST_MMIO) ? mmio_rdata : ram_rdata;

  for (genvar g = 0; g < NB; g++) begin : g_keep
    assign keep_mask[g*8 +: 8] = {8{NBW'(g) < nb_q}};
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        case (acc_route)
          RT_MMIO: state_d = ST_MMIO;
          RT_RAM:  state_d = ST_RAM;
          default: state_d = ST_RESP;
        endcase
      end
      ST_MMIO: if (mmio_ack)  state_d = ST_RESP;
      ST_RAM:  if (ram_ack)   state_d = ST_RESP;
      default: if (rsp_ready) state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      we_q    <= req_we;
      addr_q  <= req_addr;
      size_q  <= req_size;
      nb_q    <= nbytes;
      wdata_q <= req_wdata;
      kind_q  <= acc_err ? 3'd0 : dec_kind;
      err_q   <= acc_err;
      code_q  <= acc_code;
    end
  end

  always_ff @(posedge clk) begin
    if (accept)         rdata_q <= '0;
    else if (port_done) rdata_q <= we_q ? '0 : (port_data & keep_mask);
  end

  assign req_ready = (state_q == ST_IDLE);
  assign mmio_req  = (state_q == ST_MMIO);
  assign ram_req   = (state_q == ST_RAM);
  assign rsp_valid = (state_q == ST_RESP);
  assign dn_we     = we_q;
  assign dn_addr   = addr_q;
  assign dn_size   = size_q;
  assign dn_wdata  = wdata_q;
  assign dn_kind   = kind_q;
  assign rsp_err   = err_q;
  assign rsp_code  = code_q;
  assign rsp_kind  = kind_q;
  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/mad_chk.sv
module mad_chk #(
  parameter int DW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_we,
  input logic [1:0]    addr_lo,
  input logic [2:0]    req_size,
  input logic          req_aq,
  input logic          req_rl,
  input logic          req_rsv,
  input logic          prot_en,
  input logic          prot_fault,
  input logic [3:0]    prot_code,
  input logic [2:0]    dn_size,
  input logic          mmio_req,
  input logic          mmio_ack,
  input logic          ram_req,
  input logic          ram_ack,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic          rsp_err,
  input logic [3:0]    rsp_code,
  input logic [2:0]    rsp_kind,
  input logic [DW-1:0] rsp_rdata
);
  logic taken;
  assign taken = req_valid && req_ready;

  // R12
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_err) && $stable(rsp_code)
                               && $stable(rsp_kind) && $stable(rsp_rdata));

  // R12
  one_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mmio_req || ram_req) |-> !req_ready);

  // R12
  port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mmio_req && !mmio_ack) || (ram_req && !ram_ack) |=> (mmio_req || ram_req));

  // R8
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mmio_req, ram_req}));

  // R3
  ld_misal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken && !req_we && req_aq && req_size == 3'd2 && addr_lo != 2'd0
    |=> rsp_valid && rsp_err && rsp_code == 4'd4);

  // R4
  st_misal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken && req_we && req_rl && req_size == 3'd2 && addr_lo != 2'd0
    |=> rsp_valid && rsp_err && rsp_code == 4'd6);

  // R7
  prot_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken && prot_en && prot_fault && req_size == 3'd0 && !req_aq && !req_rl && !req_rsv
    |=> rsp_valid && rsp_err && rsp_code == $past(prot_code));

  // R11
  zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_err && dn_size == 3'd0 |-> rsp_rdata[DW-1:8] == '0);
endmodule

bind mem_access_dispatch mad_chk #(.DW(DW)) u_mad_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_we(req_we), .addr_lo(req_addr[1:0]), .req_size(req_size),
  .req_aq(req_aq), .req_rl(req_rl), .req_rsv(req_rsv),
  .prot_en(prot_en), .prot_fault(prot_fault), .prot_code(prot_code),
  .dn_size(dn_size), .mmio_req(mmio_req), .mmio_ack(mmio_ack),
  .ram_req(ram_req), .ram_ack(ram_ack), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_err(rsp_err), .rsp_code(rsp_code),
  .rsp_kind(rsp_kind), .rsp_rdata(rsp_rdata)
);

// File: tb/tb_mem_access_dispatch.sv
module tb_mem_access_dispatch;
  localparam int AW = 32;
  localparam int DW = 128;
  localparam logic [31:0] RIO_B = 32'h1000_0000;
  localparam logic [32:0] RIO_S = 33'h0000_1000;
  localparam logic [31:0] WIO_B = 32'h1000_0000;
  localparam logic [32:0] WIO_S = 33'h0000_0800;
  localparam logic [31:0] RAM_B = 32'h8000_0000;
  localparam logic [32:0] RAM_S = 33'h0001_0000;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_we, req_aq, req_rl, req_rsv;
  logic [1:0] req_type;
  logic [AW-1:0] req_addr;
  logic [2:0] req_size;
  logic [DW-1:0] req_wdata;
  logic prot_en, prot_fault, ram_perm_ok;
  logic [3:0] prot_code, ram_perm_code;
  logic dn_we;
  logic [AW-1:0] dn_addr;
  logic [2:0] dn_size, dn_kind;
  logic [DW-1:0] dn_wdata;
  logic mmio_req, mmio_ack, ram_req, ram_ack;
  logic [DW-1:0] mmio_rdata, ram_rdata;
  logic rsp_valid, rsp_ready, rsp_err;
  logic [3:0] rsp_code;
  logic [2:0] rsp_kind;
  logic [DW-1:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit saw_mmio, saw_ram;
  logic [2:0] seen_kind;

  always #4 clk = ~clk;

  mem_access_dispatch #(
    .AW(AW), .DW(DW), .RD_IO_BASE(RIO_B), .RD_IO_SPAN(RIO_S),
    .WR_IO_BASE(WIO_B), .WR_IO_SPAN(WIO_S), .RAM_BASE(RAM_B), .RAM_SPAN(RAM_S)
  ) dut (.*);

  function automatic logic [DW-1:0] pattern(input logic [31:0] a, input bit io);
    logic [31:0] s = io ? 32'h5A5A_0F0F : 32'h0123_4567;
    return {a ^ 32'hDEAD_BEEF, ~a, a + s, a ^ s};
  endfunction

  // one-cycle-latency responders for both ports
  always @(negedge clk) begin
    mmio_ack <= mmio_req && !mmio_ack;
    ram_ack  <= ram_req && !ram_ack;
    mmio_rdata <= pattern(dn_addr, 1'b1);
    ram_rdata  <= pattern(dn_addr, 1'b0);
    if (mmio_req && !mmio_ack) begin saw_mmio = 1'b1; seen_kind = dn_kind; end
    if (ram_req && !ram_ack)   begin saw_ram  = 1'b1; seen_kind = dn_kind; end
  end

  function automatic bit in_win(input logic [31:0] a, input int nb,
                                input logic [31:0] b, input logic [32:0] s);
    logic [32:0] lo = {1'b0, a};
    logic [32:0] hi = lo + 33'(nb);
    return (lo >= {1'b0, b}) && (hi <= {1'b0, b} + s);
  endfunction

  task automatic model(input bit we, input logic [1:0] typ, input logic [31:0] a,
                       input int sz, input logic [2:0] fl, input bit pen, input bit pf,
                       input bit pok, output bit e, output logic [3:0] c,
                       output logic [2:0] k, output int port, output string tag);
    int nb;
    bit unsup, ord;
    e = 1'b1; c = 4'd0; k = 3'd0; port = 0; unsup = 1'b0;
    if (sz > 4) begin c = 4'd15; tag = "R2"; return; end
    nb = 1 << sz;
    if (we) begin
      ord = fl[1] | fl[0];
      case (fl)
        3'b000: k = 3'd0; 3'b010: k = 3'd1; 3'b001: k = 3'd2;
        3'b011: k = 3'd3; 3'b110: k = 3'd4; 3'b111: k = 3'd5;
        default: unsup = 1'b1;
      endcase
    end else begin
      ord = fl[2] | fl[0];
      case (fl)
        3'b000: k = 3'd0; 3'b100: k = 3'd1; 3'b110: k = 3'd2;
        3'b001: k = 3'd3; 3'b101: k = 3'd4; 3'b111: k = 3'd5;
        default: unsup = 1'b1;
      endcase
    end
    if (ord && (a % nb) != 0) begin
      c = we ? 4'd6 : 4'd4; k = 3'd0; tag = we ? "R4" : "R3"; return;
    end
    if (unsup) begin c = 4'd15; k = 3'd0; tag = we ? "R6" : "R5"; return; end
    if (pen && pf) begin c = 4'hB; k = 3'd0; tag = "R7"; return; end
    if (we ? in_win(a, nb, WIO_B, WIO_S) : in_win(a, nb, RIO_B, RIO_S)) begin
      e = 1'b0; port = 1; tag = "R8"; return;
    end
    if (in_win(a, nb, RAM_B, RAM_S)) begin
      if (pok) begin e = 1'b0; port = 2; tag = "R9"; end
      else begin c = 4'hC; k = 3'd0; tag = "R9"; end
      return;
    end
    k = 3'd0; tag = "R10";
    if (we || typ > 2'd1) c = 4'd7;
    else if (typ == 2'd0) c = 4'd1;
    else c = 4'd5;
  endtask

  task automatic run_one(input bit we, input logic [1:0] typ, input logic [31:0] a,
                         input int sz, input logic [2:0] fl, input bit pen, input bit pf,
                         input bit pok, input int hold);
    bit e; logic [3:0] c; logic [2:0] k; int port; string tag;
    logic [DW-1:0] exp_d;
    int waited;
    int nb;
    model(we, typ, a, sz, fl, pen, pf, pok, e, c, k, port, tag);
    exp_d = '0;
    if (!e && !we) begin
      nb = 1 << sz;
      exp_d = pattern(a, port == 1);
      for (int b = nb; b < DW/8; b++) exp_d[b*8 +: 8] = 8'h00;
    end
    @(negedge clk);
    saw_mmio = 1'b0; saw_ram = 1'b0; seen_kind = 3'd7;
    req_we = we; req_type = typ; req_addr = a; req_size = 3'(sz);
    {req_aq, req_rl, req_rsv} = fl;
    req_wdata = {4{a}};
    prot_en = pen; prot_fault = pf; ram_perm_ok = pok;
    req_valid = 1'b1;
    @(posedge clk); #1 req_valid = 1'b0;
    waited = 0;
    while (!rsp_valid && waited < 50) begin @(negedge clk); waited++; end
    for (int h = 0; h < hold; h++) @(negedge clk);
    checks++;
    if (!rsp_valid || rsp_err !== e || rsp_code !== c || rsp_kind !== k ||
        rsp_rdata !== exp_d || saw_mmio !== (port == 1) || saw_ram !== (port == 2) ||
        (port != 0 && seen_kind !== k)) begin
      errors++;
      $display("FAIL %s R11 we=%0d typ=%0d a=%h sz=%0d fl=%b: got v=%0d e=%0d c=%0d k=%0d io=%0d ram=%0d d=%h exp e=%0d c=%0d k=%0d port=%0d d=%h",
               tag, we, typ, a, sz, fl, rsp_valid, rsp_err, rsp_code, rsp_kind,
               saw_mmio, saw_ram, rsp_rdata, e, c, k, port, exp_d);
    end
    if (hold > 0) begin
      checks++;
      if (req_ready !== 1'b0) begin
        errors++;
        $display("FAIL R12 req_ready=%0d while response pending, exp 0", req_ready);
      end
    end
    rsp_ready = 1'b1;
    @(posedge clk); #1 rsp_ready = 1'b0;
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] addrs [8];
    int n;
    addrs[0] = 32'h8000_0100; addrs[1] = 32'h8000_0103;
    addrs[2] = 32'h8000_0106; addrs[3] = 32'h8000_FFF8;
    addrs[4] = 32'h1000_0020; addrs[5] = 32'h1000_07FC;
    addrs[6] = 32'h1000_0FFF; addrs[7] = 32'h0000_4000;
    rst_n = 1'b0; req_valid = 1'b0; rsp_ready = 1'b0;
    req_we = 1'b0; req_type = 2'd0; req_addr = '0; req_size = 3'd0;
    req_aq = 1'b0; req_rl = 1'b0; req_rsv = 1'b0; req_wdata = '0;
    prot_en = 1'b0; prot_fault = 1'b0; prot_code = 4'hB;
    ram_perm_ok = 1'b1; ram_perm_code = 4'hC;
    mmio_ack = 1'b0; ram_ack = 1'b0; mmio_rdata = '0; ram_rdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (req_ready !== 1'b1 || rsp_valid !== 1'b0 || mmio_req !== 1'b0 || ram_req !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset state rdy=%0d v=%0d io=%0d ram=%0d exp 1 0 0 0",
               req_ready, rsp_valid, mmio_req, ram_req);
    end
    n = 0;
    for (int pv = 0; pv < 4; pv++)
      for (int ai = 0; ai < 8; ai++)
        for (int sz = 0; sz < 5; sz++)
          for (int fl = 0; fl < 8; fl++)
            for (int we = 0; we < 2; we++)
              for (int typ = 0; typ < 3; typ++) begin
                run_one(we[0], 2'(typ), addrs[ai], sz, 3'(fl), pv[1], pv[0],
                        ((ai + sz + fl) % 4) != 0, n % 3);
                n++;
              end
    // R2: oversize codes
    for (int sz = 5; sz < 8; sz++)
      for (int we = 0; we < 2; we++)
        run_one(we[0], 2'd1, addrs[0], sz, 3'b000, 1'b0, 1'b0, 1'b1, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule